// File: doc/BRIEF.md
# Segment Base-Bound Address Translator

This block maps a 32-bit logical address onto a physical address through a small table of segment descriptors. The upper ten bits of the logical address choose a descriptor and the lower twenty-two bits are an offset inside that segment. Each descriptor holds a base address, a segment size, access rights and a valid flag. A separate limit register caps the segment numbers that are legal.

A request carries an address and an access type. The result is either the physical address (base plus offset) or a fault code. The descriptors and the limit register are loaded through a simple write port. The translation is computed combinationally, and the result is registered and presented one cycle after the request with a strobe.

Top module: `seg_xlate`

## Requirements
- R1: The logical address is split into a segment number `req_addr[31:22]` and an offset `req_addr[21:0]`.
- R2: On success `rsp_fault` is 0 and `rsp_pa` equals the descriptor base plus the zero-extended offset, modulo 2^32. Whenever `rsp_fault` is nonzero, `rsp_pa` is 0.
- R3: Fault code 1 is reported in three cases: the segment number is at or above the limit register, the segment number is at or above the table depth (16 by default), or the descriptor's valid flag is clear.
- R4: Access rights are held as a 3-bit field: bit 0 allows reads, bit 1 allows writes and bit 2 allows execution. The access type allows fetch as 0 (needs bit 2), read as 1 (needs bit 0) and write as 2 (needs bit 1). Type 3 is never allowed. A request that is not allowed reports fault code 2.
- R5: An offset that is greater than or equal to the descriptor's size reports fault code 3. An offset of size minus one is accepted.
- R6: The checks are applied in a fixed order: segment validity, then rights, then size. Only the first failing check is reported.
- R7: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `rsp_pa` and `rsp_fault` are 0.
- R8: A descriptor write takes effect on the following cycle. A request made in the same cycle as the write is translated with the old descriptor.
- R9: After reset every descriptor is invalid, the limit register is 0 and `rsp_valid` is low.
- R10: A write to the limit register changes which segment numbers are legal from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_idx | input | 4 | Descriptor index to write |
| cfg_base | input | 32 | Segment base address |
| cfg_size | input | 23 | Segment size in bytes |
| cfg_perm | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| cfg_vld | input | 1 | Descriptor valid flag |
| lim_we | input | 1 | Limit register write enable |
| lim_val | input | 11 | New limit: number of legal segments |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Logical address |
| req_type | input | 2 | Access type: 0 fetch, 1 read, 2 write |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 2 | 0 none, 1 segment, 2 rights, 3 size |

## Verification
Every cycle, the assertions check four things: the one-cycle relation between request and response strobes, that address and fault are zeroed when idle or faulting, that a segment number at or above the limit always reports code 1, and that the reserved access type always faults. Other behaviour can only be shown by the bench's directed scenarios. These are the base-plus-offset arithmetic including wraparound, each rights combination, the exact size edge, the priority between simultaneous faults, and the old-versus-new descriptor seen when a write and a request share a cycle.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 10,
  parameter int OFF_W = 22,
  parameter int PA_W  = 32,
  parameter int DEPTH = 16,
  localparam int VA_W  = SEG_W + OFF_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [OFF_W:0]   cfg_size,
  input  logic [2:0]       cfg_perm,
  input  logic             cfg_vld,
  input  logic             lim_we,
  input  logic [SEG_W:0]   lim_val,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_addr,
  input  logic [1:0]       req_type,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_fault
);

  logic [PA_W-1:0]  t_base [DEPTH];
  logic [OFF_W:0]   t_size [DEPTH];
  logic [2:0]       t_perm [DEPTH];
  logic [DEPTH-1:0] t_vld;
  logic [SEG_W:0]   lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_vld <= '0;
      lim   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        t_base[i] <= '0;
        t_size[i] <= '0;
        t_perm[i] <= '0;
      end
    end else begin
      if (cfg_we) begin
        t_base[cfg_idx] <= cfg_base;
        t_size[cfg_idx] <= cfg_size;
        t_perm[cfg_idx] <= cfg_perm;
        t_vld[cfg_idx]  <= cfg_vld;
      end
      if (lim_we) lim <= lim_val;
    end
  end

  wire [SEG_W-1:0] seg = req_addr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] off = req_addr[OFF_W-1:0];
  wire [IDX_W-1:0] idx = seg[IDX_W-1:0];

  wire in_tbl = ({1'b0, seg} < lim) && ({1'b0, seg} < (SEG_W+1)'(DEPTH));
  wire seg_ok = in_tbl && t_vld[idx];

  logic perm_ok;
  always_comb begin
    case (req_type)
      2'd0:    perm_ok = t_perm[idx][2];
      2'd1:    perm_ok = t_perm[idx][0];
      2'd2:    perm_ok = t_perm[idx][1];
      default: perm_ok = 1'b0;
    endcase
  end

  wire size_ok = {1'b0, off} < t_size[idx];

  logic [1:0] c_fault;
  always_comb begin
    if (!seg_ok)       c_fault = 2'd1;
    else if (!perm_ok) c_fault = 2'd2;
    else if (!size_ok) c_fault = 2'd3;
    else               c_fault = 2'd0;
  end

  wire [PA_W-1:0] c_pa = (c_fault == 2'd0) ? t_base[idx] + PA_W'(off) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_pa    <= req_valid ? c_pa : '0;
      rsp_fault <= req_valid ? c_fault : 2'd0;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R7
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !rsp_valid |-> (rsp_pa == '0 && rsp_fault == 2'd0)); // R7
  AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault != 2'd0) |-> rsp_pa == '0); // R2
  AST_LIMIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && {1'b0, req_addr[VA_W-1:OFF_W]} >= lim) |=> rsp_fault == 2'd1); // R3
  AST_RESERVED_TYPE: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_type == 2'd3) |=> rsp_fault != 2'd0); // R4

endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_idx = 0;
  logic [31:0] cfg_base = 0;
  logic [22:0] cfg_size = 0;
  logic [2:0]  cfg_perm = 0;
  logic        cfg_vld = 0;
  logic        lim_we = 0;
  logic [10:0] lim_val = 0;
  logic        req_valid = 0;
  logic [31:0] req_addr = 0;
  logic [1:0]  req_type = 0;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_fault;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  seg_xlate u_dut (.*);

  function automatic logic [31:0] va(input int s, input int o);
    return {s[9:0], o[21:0]};
  endfunction

  task automatic check(input string tag, input logic [1:0] ef, input logic [31:0] epa);
    n_chk++;
    if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_pa !== epa) begin
      n_bad++;
      $display("FAIL %s: got v=%0b f=%0d pa=%h, exp v=1 f=%0d pa=%h", tag, rsp_valid, rsp_fault, rsp_pa, ef, epa);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] b, input int sz, input logic [2:0] p, input logic v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = i[3:0]; cfg_base = b; cfg_size = sz[22:0]; cfg_perm = p; cfg_vld = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_lim(input int l);
    @(negedge clk);
    lim_we = 1; lim_val = l[10:0];
    @(negedge clk);
    lim_we = 0;
  endtask

  task automatic xl(input string tag, input logic [31:0] a, input logic [1:0] t,
                    input logic [1:0] ef, input logic [31:0] epa);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_type = t;
    @(negedge clk);
    req_valid = 0;
    check(tag, ef, epa);
  endtask

  task automatic t_reset;
    n_chk++;
    if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_pa !== 0) begin
      n_bad++;
      $display("FAIL R9 reset outputs: got v=%0b f=%0d pa=%h, exp 0", rsp_valid, rsp_fault, rsp_pa);
    end
    xl("R9 limit 0 after reset", va(0, 0), 2'd1, 2'd1, 0);
  endtask

  task automatic t_setup;
    set_lim(8);
    wr(0, 32'h1000_0000, 'h400, 3'b101, 1);
    wr(1, 32'h2000_0000, 'h10_0000, 3'b011, 1);
    wr(2, 32'h3000_0000, 'h100, 3'b111, 0);
    wr(3, 32'hFFFF_FF00, 'h200, 3'b001, 1);
  endtask

  task automatic t_translate;
    xl("R1 R2 fetch seg0", va(0, 'h10), 2'd0, 2'd0, 32'h1000_0010);
    xl("R1 R2 write seg1", va(1, 'h12345), 2'd2, 2'd0, 32'h2001_2345);
    xl("R2 wraparound seg3", va(3, 'h150), 2'd1, 2'd0, 32'h0000_0050);
  endtask

  task automatic t_perm;
    xl("R4 write to RX seg", va(0, 'h10), 2'd2, 2'd2, 0);
    xl("R4 fetch from RW seg", va(1, 'h10), 2'd0, 2'd2, 0);
    xl("R4 reserved type", va(1, 'h10), 2'd3, 2'd2, 0);
    xl("R4 read from RW seg", va(1, 'h20), 2'd1, 2'd0, 32'h2000_0020);
  endtask

  task automatic t_size;
    xl("R5 last byte", va(0, 'h3FF), 2'd1 + 2'd1, 2'd2, 0);
    xl("R5 last byte fetch", va(0, 'h3FF), 2'd0, 2'd0, 32'h1000_03FF);
    xl("R5 at size", va(0, 'h400), 2'd0, 2'd3, 0);
    xl("R5 max offset", va(1, 'h3F_FFFF), 2'd1, 2'd3, 0);
  endtask

  task automatic t_order;
    xl("R6 R3 invalid beats rights", va(2, 'h500), 2'd3, 2'd1, 0);
    xl("R6 rights beat size", va(0, 'h500), 2'd2, 2'd2, 0);
    xl("R3 seg at limit", va(8, 0), 2'd1, 2'd1, 0);
    wr(9, 32'h0000_4000, 'h100, 3'b111, 1);
    xl("R3 seg9 above limit", va(9, 4), 2'd1, 2'd1, 0);
    set_lim(10);
    xl("R10 seg9 after raise", va(9, 4), 2'd1, 2'd0, 32'h0000_4004);
    set_lim(1023);
    xl("R3 seg beyond depth", va(25, 4), 2'd1, 2'd1, 0);
    xl("R3 seg beyond depth alias", va(16 + 9, 4), 2'd0, 2'd1, 0);
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'd1; cfg_base = 32'h5000_0000; cfg_size = 23'h100; cfg_perm = 3'b001; cfg_vld = 1;
    req_valid = 1; req_addr = va(1, 'h40); req_type = 2'd1;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    check("R8 same-cycle sees old", 2'd0, 32'h2000_0040);
    xl("R8 next cycle sees new", va(1, 'h40), 2'd1, 2'd0, 32'h5000_0040);
  endtask

  task automatic t_idle;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 0 || rsp_pa !== 0 || rsp_fault !== 0) begin
      n_bad++;
      $display("FAIL R7 idle: got v=%0b f=%0d pa=%h, exp 0", rsp_valid, rsp_fault, rsp_pa);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    t_setup;
    t_translate;
    t_perm;
    t_size;
    t_order;
    t_write_timing;
    t_idle;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule